// File: doc/BRIEF.md
# Single-Cycle Data RAM with Store Bypass

This block is the data memory of a pipelined core's load/store stage. It wraps a synchronous two-port RAM array. The array commits a write on a clock edge. A read of the same word on that same edge returns the contents from before the write. The wrapper takes one store and one load per cycle, each with a word address. A store also carries byte enables and data. Load data comes back exactly one cycle after the load is presented.

A store and a load presented together are treated as store-then-load, so the load must see the store. A build-time parameter picks how that same-cycle conflict is resolved. In forward mode, the store's enabled bytes are captured in a one-entry bypass register. They are merged over the RAM output in the response cycle, with no stall. In interlock mode, the block raises `ld_stall` in the conflict cycle and drops the load while still committing the store. The requester reissues the load in the next cycle and reads the committed value from the array.

A small read-response state machine drives the load result. Its states are:
- `RD_IDLE`: no result this cycle, data forced to zero.
- `RD_RAM`: the result comes straight from the array.
- `RD_MERGE`: the result is the array output with bypassed bytes laid over it.

Its transitions are:
- *accept-plain*: a load is accepted with no conflict, leading to `RD_RAM`.
- *accept-bypass*: a load is accepted with a forwarded conflict, leading to `RD_MERGE`.
- *no-accept*: there is no load, or the load is stalled, leading to `RD_IDLE`.

Each transition can be taken from any state.

Top module: `dram_fwd`

## Requirements
- R1: After reset, with no request, `ld_rvalid`, `ld_stall` and `ld_rdata` are all zero.
- R2: A load accepted in cycle k (`ld_valid` high, `ld_stall` low) gives `ld_rvalid` high in cycle k+1 with the word's data on `ld_rdata`.
- R3: A store writes only the bytes whose enable is set; enable bit b covers data bits 8b+7..8b, and other bytes of the word keep their contents.
- R4: Stores in consecutive cycles, to adjacent words or to different bytes of one word, are all committed.
- R5: In forward mode, a load and a store to the same word in the same cycle return the stored bytes in cycle k+1 without a stall.
- R6: In a forwarded result, bytes not enabled by the store come from the array's prior contents.
- R7: In interlock mode, a same-cycle same-word load and store with at least one enabled byte raise `ld_stall` in that cycle. No result follows in the next cycle, the store still commits, and a reissued load returns the new value.
- R8: A load in the cycle after a store to the same word returns the stored value in both modes, with no stall.
- R9: `ld_stall` is never raised in forward mode. In interlock mode it is low when the addresses differ, when either request is absent, or when no byte is enabled.
- R10: While `ld_rvalid` is low, `ld_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request this cycle |
| st_addr | input | ADDR_W | Store word address |
| st_be | input | DATA_W/8 | Store byte enables |
| st_data | input | DATA_W | Store data |
| ld_valid | input | 1 | Load request this cycle |
| ld_addr | input | ADDR_W | Load word address |
| ld_stall | output | 1 | Load refused this cycle (interlock mode only) |
| ld_rvalid | output | 1 | Load result present |
| ld_rdata | output | DATA_W | Load result, zero when no result |

## Verification
`ld_stall` is combinational, so the bench checks it one nanosecond after driving inputs in the request cycle. `ld_rvalid` and `ld_rdata` are due one edge later. The bench drives at a falling edge and checks the previous request's result at the next falling edge, after exactly one rising edge. A forward-mode and an interlock-mode instance receive identical stimulus. Each is compared against a byte-accurate reference memory updated on every store. Directed cases cover partial, adjacent and same-cycle stores, interlock reissue and back-to-back stores. A random phase then packs requests into two-word windows to force frequent conflicts.

// File: rtl/dram_fwd_pkg.sv
package dram_fwd_pkg;
    // Read-response state: what ld_rdata carries this cycle
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_RAM   = 2'd1,
        RD_MERGE = 2'd2
    } rd_state_e;
endpackage

// File: rtl/dfm_ram.sv
module dfm_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int NB    = DATA_W / 8;
    localparam int DEPTH = 1 << ADDR_W;

    // One array per byte lane; a read on the write edge returns old contents
    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];
        logic [7:0] lane_q;

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) begin
                lane_mem[wr_addr] <= wr_data[b*8 +: 8];
            end
            if (rd_en) begin
                lane_q <= lane_mem[rd_addr];
            end
        end

        assign rd_data[b*8 +: 8] = lane_q;
    end
endmodule

// File: rtl/dfm_hazard.sv
module dfm_hazard #(
    parameter int ADDR_W = 6,
    parameter int NB     = 4,
    parameter bit FWD_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [NB-1:0]     st_be,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              stall,
    output logic              fwd_take
);
    logic conflict;

    assign conflict = st_valid && ld_valid && (st_addr == ld_addr) && (|st_be);

    if (FWD_EN) begin : g_forward
        assign stall    = 1'b0;
        assign fwd_take = conflict;
    end else begin : g_interlock
        assign stall    = conflict;
        assign fwd_take = 1'b0;
    end

    // R9
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (st_valid && ld_valid));
endmodule

// File: rtl/dfm_byp_reg.sv
module dfm_byp_reg #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap,
    input  logic [DATA_W/8-1:0] st_be,
    input  logic [DATA_W-1:0]   st_data,
    output logic [DATA_W/8-1:0] byp_be,
    output logic [DATA_W-1:0]   byp_data
);
    // One-entry holding register for the store being bypassed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byp_be   <= '0;
            byp_data <= '0;
        end else begin
            byp_be <= cap ? st_be : '0;
            if (cap) begin
                byp_data <= st_data;
            end
        end
    end
endmodule

// File: rtl/dram_fwd.sv
module dram_fwd
    import dram_fwd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter bit FWD_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_valid,
    input  logic [ADDR_W-1:0]   st_addr,
    input  logic [DATA_W/8-1:0] st_be,
    input  logic [DATA_W-1:0]   st_data,
    input  logic                ld_valid,
    input  logic [ADDR_W-1:0]   ld_addr,
    output logic                ld_stall,
    output logic                ld_rvalid,
    output logic [DATA_W-1:0]   ld_rdata
);
    localparam int NB = DATA_W / 8;

    rd_state_e         state_q, state_d;
    logic              fwd_take;
    logic              rd_go;
    logic [DATA_W-1:0] ram_q;
    logic [NB-1:0]     byp_be;
    logic [DATA_W-1:0] byp_data;
    logic [DATA_W-1:0] merged;

    dfm_hazard #(.ADDR_W(ADDR_W), .NB(NB), .FWD_EN(FWD_EN)) u_hazard (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_valid (st_valid),
        .st_addr  (st_addr),
        .st_be    (st_be),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .stall    (ld_stall),
        .fwd_take (fwd_take)
    );

    assign rd_go = ld_valid && !ld_stall;

    dfm_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk     (clk),
        .wr_en   (st_valid),
        .wr_addr (st_addr),
        .wr_be   (st_be),
        .wr_data (st_data),
        .rd_en   (rd_go),
        .rd_addr (ld_addr),
        .rd_data (ram_q)
    );

    dfm_byp_reg #(.DATA_W(DATA_W)) u_byp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (fwd_take),
        .st_be    (st_be),
        .st_data  (st_data),
        .byp_be   (byp_be),
        .byp_data (byp_data)
    );

    // Byte-wise overlay of the bypassed store on the array output
    for (genvar b = 0; b < NB; b++) begin : g_merge
        assign merged[b*8 +: 8] = byp_be[b] ? byp_data[b*8 +: 8] : ram_q[b*8 +: 8];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept-bypass, accept-plain, no-accept
    always_comb begin
        if (rd_go && fwd_take) begin
            state_d = RD_MERGE;
        end else if (rd_go) begin
            state_d = RD_RAM;
        end else begin
            state_d = RD_IDLE;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            RD_RAM: begin
                ld_rvalid = 1'b1;
                ld_rdata  = ram_q;
            end
            RD_MERGE: begin
                ld_rvalid = 1'b1;
                ld_rdata  = merged;
            end
            default: begin
                ld_rvalid = 1'b0;
                ld_rdata  = '0;
            end
        endcase
    end

    // R2
    ld_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_stall) |=> ld_rvalid);

    // R2
    rvalid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rvalid |-> $past(ld_valid));

    // R7
    stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stall |=> !ld_rvalid);

    // R5
    merge_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_MERGE) |-> $past(st_valid && ld_valid && (st_addr == ld_addr)));
endmodule

// File: tb/dram_fwd_test.sv
`timescale 1ns/1ps
module dram_fwd_test;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NB = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          st_valid, ld_valid;
    logic [AW-1:0] st_addr, ld_addr;
    logic [NB-1:0] st_be;
    logic [DW-1:0] st_data;

    logic          f_stall, f_rvalid, i_stall, i_rvalid;
    logic [DW-1:0] f_rdata, i_rdata;

    dram_fwd #(.ADDR_W(AW), .DATA_W(DW), .FWD_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_be(st_be), .st_data(st_data), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_stall(f_stall), .ld_rvalid(f_rvalid), .ld_rdata(f_rdata));

    dram_fwd #(.ADDR_W(AW), .DATA_W(DW), .FWD_EN(1'b0)) uut_lock (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_be(st_be), .st_data(st_data), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_stall(i_stall), .ld_rvalid(i_rvalid), .ld_rdata(i_rdata));

    int n_chk = 0;
    int n_err = 0;

    logic [DW-1:0] model [DEPTH];
    bit            pend = 1'b0;
    string         pend_req;
    logic          exp_fv, exp_iv;
    logic [DW-1:0] exp_fd, exp_id;

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] overlay(logic [DW-1:0] old, logic [NB-1:0] be,
                                              logic [DW-1:0] d);
        logic [DW-1:0] r = old;
        for (int b = 0; b < NB; b++) begin
            if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
        end
        return r;
    endfunction

    task automatic step(bit sv, logic [AW-1:0] sa, logic [NB-1:0] sbe, logic [DW-1:0] sd,
                        bit lv, logic [AW-1:0] la, string req);
        logic          conflict;
        logic [DW-1:0] seen;
        @(negedge clk);
        if (pend) begin
            chk({pend_req, " fwd valid"}, {31'd0, f_rvalid}, {31'd0, exp_fv});
            chk(exp_fv ? {pend_req, " fwd data"} : "R10 fwd idle data", f_rdata, exp_fd);
            chk({pend_req, " lock valid"}, {31'd0, i_rvalid}, {31'd0, exp_iv});
            chk(exp_iv ? {pend_req, " lock data"} : "R10 lock idle data", i_rdata, exp_id);
        end
        st_valid = sv; st_addr = sa; st_be = sbe; st_data = sd;
        ld_valid = lv; ld_addr = la;
        #1;
        conflict = sv && lv && (sa == la) && (|sbe);
        chk("R9 fwd stall", {31'd0, f_stall}, 32'd0);
        chk(conflict ? "R7 lock stall" : "R9 lock stall", {31'd0, i_stall}, {31'd0, conflict});
        seen   = (sv && sa == la) ? overlay(model[la], sbe, sd) : model[la];
        exp_fv = lv;
        exp_fd = lv ? seen : '0;
        exp_iv = lv && !conflict;
        exp_id = exp_iv ? seen : '0;
        if (sv) model[sa] = overlay(model[sa], sbe, sd);
        pend     = 1'b1;
        pend_req = req;
    endtask

    task automatic idle(string req);
        step(1'b0, '0, '0, '0, 1'b0, '0, req);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20241115));
        rst_n = 1'b0;
        st_valid = 1'b0; st_addr = '0; st_be = '0; st_data = '0;
        ld_valid = 1'b0; ld_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 fwd rvalid", {31'd0, f_rvalid}, 32'd0);
        chk("R1 fwd rdata", f_rdata, 32'd0);
        chk("R1 fwd stall", {31'd0, f_stall}, 32'd0);
        chk("R1 lock rvalid", {31'd0, i_rvalid}, 32'd0);
        chk("R1 lock rdata", i_rdata, 32'd0);
        chk("R1 lock stall", {31'd0, i_stall}, 32'd0);

        // Fill the array so every word is defined
        for (int a = 0; a < DEPTH; a++) begin
            step(1'b1, AW'(a), '1, $urandom(), 1'b0, '0, "R4 fill");
        end
        idle("R10");

        // R2 plain loads
        step(1'b0, '0, '0, '0, 1'b1, 6'd5, "R2 plain load");
        step(1'b0, '0, '0, '0, 1'b1, 6'd6, "R2 plain load back-to-back");
        // R3 partial store, then read later
        step(1'b1, 6'd9, 4'b0101, 32'hA1B2C3D4, 1'b0, '0, "R3");
        idle("R10");
        step(1'b0, '0, '0, '0, 1'b1, 6'd9, "R3 partial store");
        // R4 back-to-back adjacent stores and same-word byte stores
        step(1'b1, 6'd20, '1, 32'h11112222, 1'b0, '0, "R4");
        step(1'b1, 6'd21, '1, 32'h33334444, 1'b0, '0, "R4");
        step(1'b1, 6'd22, 4'b0011, 32'h0000BEEF, 1'b0, '0, "R4");
        step(1'b1, 6'd22, 4'b1100, 32'hCAFE0000, 1'b0, '0, "R4");
        step(1'b0, '0, '0, '0, 1'b1, 6'd20, "R4 adjacent first");
        step(1'b0, '0, '0, '0, 1'b1, 6'd21, "R4 adjacent second");
        step(1'b0, '0, '0, '0, 1'b1, 6'd22, "R4 split bytes");
        // R5 same-cycle full store and load; R7 interlock then reissue
        step(1'b1, 6'd30, '1, 32'hDEADBEEF, 1'b1, 6'd30, "R5 same-cycle forward");
        step(1'b0, '0, '0, '0, 1'b1, 6'd30, "R7 reissue after stall");
        // R6 partial forward
        step(1'b1, 6'd31, 4'b1001, 32'h77000088, 1'b1, 6'd31, "R6 partial forward");
        step(1'b0, '0, '0, '0, 1'b1, 6'd31, "R7 reissue partial");
        // R8 load right after store
        step(1'b1, 6'd40, 4'b0110, 32'h00ABCD00, 1'b0, '0, "R8");
        step(1'b0, '0, '0, '0, 1'b1, 6'd40, "R8 next-cycle load");
        // R9 different address, and zero enables on same word
        step(1'b1, 6'd41, '1, 32'h12345678, 1'b1, 6'd42, "R9 other address");
        step(1'b1, 6'd42, 4'b0000, 32'hFFFFFFFF, 1'b1, 6'd42, "R9 no enables");
        idle("R10");

        // Random phase: narrow windows to force conflicts
        for (int n = 0; n < 2000; n++) begin
            logic [AW-1:0] base;
            base = AW'($urandom() % DEPTH);
            step(($urandom() % 10) < 7, base + AW'($urandom() % 2), NB'($urandom()), $urandom(),
                 ($urandom() % 10) < 7, base + AW'($urandom() % 2), "R5 R6 R8 random");
        end
        idle("R10");
        idle("R10");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule